// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds sixteen general registers for a processor core. Some of the upper registers are private to a processor mode. A 5-bit mode code is decoded into one of eight banks. When a mode write selects a different bank, the live registers affected by that bank are saved into shadow storage, and the incoming bank's copies are loaded. The whole exchange completes at one clock edge.

The core uses two combinational read ports and one write port, all of which see the registers of the current mode. A separate debug port can read or write any register as seen from any mode. When the requested mode decodes to another bank, the access goes to that bank's shadow copy. When it decodes to the current bank, the access goes to the live register.

Banks share storage unevenly. The user, interrupt, supervisor, abort, undefined and system banks each own only r13 and r14. The fast-interrupt bank owns r8 through r14. A dummy bank absorbs every undefined mode code.

Top module: `mbrf_regfile`

## Requirements
- R1: After reset every register and every shadow copy is zero, and `cur_mode` reads 5'h13.
- R2: Mode codes decode to banks as follows. For codes 5'h00 to 5'h03, and again for 5'h10 to 5'h13, the low two bits select user, fast-interrupt, interrupt and supervisor in that order. 5'h17 is abort, 5'h1B is undefined and 5'h1F is system. Every other code is the dummy bank.
- R3: A write on the write port updates the live register at `wr_addr` at the next edge. `rd_data_a` and `rd_data_b` show the live register at their address combinationally.
- R4: The user, interrupt, supervisor, abort, undefined and system banks each keep their own r13 and r14. These are saved and restored when the bank changes.
- R5: On entry to the fast-interrupt bank, the live r8 to r12 are saved to the user store, and r8 to r14 are loaded from the fast-interrupt store. On exit, r8 to r14 are saved to the fast-interrupt store, and r8 to r12 are reloaded from the user store.
- R6: On entry to the dummy bank, the live r8 to r14 become zero. On exit from it, the dummy shadow r8 to r14 is cleared.
- R7: A mode write whose new code decodes to the current bank moves no register contents. Only `cur_mode` changes.
- R8: r0 to r7 and r15 are shared by every mode and never change on a bank switch.
- R9: The debug port reads combinationally. For r8 to r14 of a bank other than the current one, it accesses that bank's shadow store. Reading user r8 to r12 while in the fast-interrupt bank returns the saved user copies. All other debug accesses go to the live register.
- R10: In a cycle with a bank switch, a debug write is applied before the save. A write-port write is applied after the restore, so it lands in the new mode's register.
- R11: `cur_mode` equals the code of the most recent mode write, from the edge after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_a | input | 4 | Read port A register index |
| rd_data_a | output | DATA_W | Read port A data |
| rd_addr_b | input | 4 | Read port B register index |
| rd_data_b | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 4 | Write port register index |
| wr_data | input | DATA_W | Write port data |
| mode_we | input | 1 | Load a new mode code |
| mode_wdata | input | 5 | New mode code |
| cur_mode | output | 5 | Current mode code |
| dbg_we | input | 1 | Debug write enable |
| dbg_mode | input | 5 | Mode whose view the debug port uses |
| dbg_addr | input | 4 | Debug register index |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_rdata | output | DATA_W | Debug read data |

## Verification
A save that goes to the wrong slot stays hidden until the debug port looks at that bank, or until the code returns to it. The bench therefore reads shadow copies through the debug port right after each switch, and again after returning. A wrong restore shows on the read ports in the first cycle after the switching edge. A missed dummy-bank clear shows only on a later debug read of a dummy code, so that read is made after leaving the bank.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

    localparam int MODE_W     = 5;
    localparam int NUM_REGS   = 16;
    localparam int ADDR_W     = $clog2(NUM_REGS);
    localparam int BANK_LO    = 8;
    localparam int USR_SHARED = 5;
    localparam int FIQ_PRIV   = 7;
    localparam int NUM_PRIV   = 6;
    localparam int SLOT_W     = $clog2(NUM_PRIV);
    localparam int HI_IDX_W   = $clog2(FIQ_PRIV);

    localparam logic [MODE_W-1:0] RESET_MODE = 5'b10011;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5,
        BK_SYS = 3'd6,
        BK_DUM = 3'd7
    } bank_e;

    typedef enum logic [2:0] {
        LOC_LIVE  = 3'd0,
        LOC_USRHI = 3'd1,
        LOC_FIQ   = 3'd2,
        LOC_DUM   = 3'd3,
        LOC_PRIV  = 3'd4
    } loc_e;

    function automatic logic [SLOT_W-1:0] priv_slot(input bank_e b);
        case (b)
            BK_USR:  priv_slot = SLOT_W'(0);
            BK_IRQ:  priv_slot = SLOT_W'(1);
            BK_SVC:  priv_slot = SLOT_W'(2);
            BK_ABT:  priv_slot = SLOT_W'(3);
            BK_UND:  priv_slot = SLOT_W'(4);
            default: priv_slot = SLOT_W'(5);
        endcase
    endfunction

endpackage

// File: rtl/mbrf_bank_map.sv
module mbrf_bank_map
    import mbrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank
);

    always_comb begin
        if (mode[3:2] == 2'b00) begin
            case (mode[1:0])
                2'd0:    bank = BK_USR;
                2'd1:    bank = BK_FIQ;
                2'd2:    bank = BK_IRQ;
                default: bank = BK_SVC;
            endcase
        end else begin
            case (mode)
                5'h17:   bank = BK_ABT;
                5'h1B:   bank = BK_UND;
                5'h1F:   bank = BK_SYS;
                default: bank = BK_DUM;
            endcase
        end
    end

endmodule

// File: rtl/mbrf_locator.sv
module mbrf_locator
    import mbrf_pkg::*;
(
    input  bank_e               tgt_bank,
    input  bank_e               cur_bank,
    input  logic [ADDR_W-1:0]   addr,
    output loc_e                kind,
    output logic [HI_IDX_W-1:0] hi_idx,
    output logic [SLOT_W-1:0]   slot,
    output logic                r14_sel
);

    logic banked_reg;

    always_comb begin
        banked_reg = (addr >= ADDR_W'(BANK_LO)) && (addr <= ADDR_W'(BANK_LO + FIQ_PRIV - 1));
        hi_idx     = addr[HI_IDX_W-1:0];
        slot       = priv_slot(tgt_bank);
        r14_sel    = (addr == ADDR_W'(BANK_LO + FIQ_PRIV - 1));
        kind       = LOC_LIVE;
        if (banked_reg && (tgt_bank != cur_bank)) begin
            if (tgt_bank == BK_FIQ) begin
                kind = LOC_FIQ;
            end else if (tgt_bank == BK_DUM) begin
                kind = LOC_DUM;
            end else if (addr >= ADDR_W'(BANK_LO + USR_SHARED)) begin
                kind = LOC_PRIV;
            end else if (cur_bank == BK_FIQ) begin
                kind = LOC_USRHI;
            end else begin
                kind = LOC_LIVE;
            end
        end
    end

endmodule

// File: rtl/mbrf_read_port.sv
module mbrf_read_port
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [ADDR_W-1:0]               addr,
    output logic [DATA_W-1:0]               data
);

    always_comb begin
        data = regs[addr];
    end

endmodule

// File: rtl/mbrf_regfile.sv
module mbrf_regfile
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    rd_addr_a,
    output logic [DATA_W-1:0]    rd_data_a,
    input  logic [ADDR_W-1:0]    rd_addr_b,
    output logic [DATA_W-1:0]    rd_data_b,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 mode_we,
    input  logic [MODE_W-1:0]    mode_wdata,
    output logic [MODE_W-1:0]    cur_mode,
    input  logic                 dbg_we,
    input  logic [MODE_W-1:0]    dbg_mode,
    input  logic [ADDR_W-1:0]    dbg_addr,
    input  logic [DATA_W-1:0]    dbg_wdata,
    output logic [DATA_W-1:0]    dbg_rdata
);

    localparam int NUM_RD = 2;

    typedef struct packed {
        logic [MODE_W-1:0]                     mode;
        logic [NUM_REGS-1:0][DATA_W-1:0]       live;
        logic [NUM_PRIV-1:0][1:0][DATA_W-1:0]  priv;
        logic [USR_SHARED-1:0][DATA_W-1:0]     usr_hi;
        logic [FIQ_PRIV-1:0][DATA_W-1:0]       fiq_hi;
        logic [FIQ_PRIV-1:0][DATA_W-1:0]       dum_hi;
    } state_t;

    state_t state_d, state_q;

    bank_e cur_bank, new_bank, dbg_bank;

    mbrf_bank_map u_map_cur (.mode(state_q.mode), .bank(cur_bank));
    mbrf_bank_map u_map_new (.mode(mode_wdata),   .bank(new_bank));
    mbrf_bank_map u_map_dbg (.mode(dbg_mode),     .bank(dbg_bank));

    loc_e                dbg_kind;
    logic [HI_IDX_W-1:0] dbg_idx;
    logic [SLOT_W-1:0]   dbg_slot;
    logic                dbg_r14;

    mbrf_locator u_loc (
        .tgt_bank (dbg_bank),
        .cur_bank (cur_bank),
        .addr     (dbg_addr),
        .kind     (dbg_kind),
        .hi_idx   (dbg_idx),
        .slot     (dbg_slot),
        .r14_sel  (dbg_r14)
    );

    logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_arr;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data_arr;

    assign rd_addr_arr[0] = rd_addr_a;
    assign rd_addr_arr[1] = rd_addr_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        mbrf_read_port #(.DATA_W(DATA_W)) u_rd (
            .regs (state_q.live),
            .addr (rd_addr_arr[p]),
            .data (rd_data_arr[p])
        );
    end

    assign rd_data_a = rd_data_arr[0];
    assign rd_data_b = rd_data_arr[1];
    assign cur_mode  = state_q.mode;

    always_comb begin
        case (dbg_kind)
            LOC_USRHI: dbg_rdata = state_q.usr_hi[dbg_idx];
            LOC_FIQ:   dbg_rdata = state_q.fiq_hi[dbg_idx];
            LOC_DUM:   dbg_rdata = state_q.dum_hi[dbg_idx];
            LOC_PRIV:  dbg_rdata = state_q.priv[dbg_slot][dbg_r14];
            default:   dbg_rdata = state_q.live[dbg_addr];
        endcase
    end

    logic swap;
    assign swap = mode_we && (new_bank != cur_bank);

    always_comb begin
        state_d = state_q;

        // debug write lands before any bank exchange
        if (dbg_we) begin
            case (dbg_kind)
                LOC_USRHI: state_d.usr_hi[dbg_idx]          = dbg_wdata;
                LOC_FIQ:   state_d.fiq_hi[dbg_idx]          = dbg_wdata;
                LOC_DUM:   state_d.dum_hi[dbg_idx]          = dbg_wdata;
                LOC_PRIV:  state_d.priv[dbg_slot][dbg_r14]  = dbg_wdata;
                default:   state_d.live[dbg_addr]           = dbg_wdata;
            endcase
        end

        if (swap) begin
            // save outgoing bank
            case (cur_bank)
                BK_FIQ: begin
                    for (int i = 0; i < FIQ_PRIV; i++) begin
                        state_d.fiq_hi[i] = state_d.live[BANK_LO + i];
                    end
                end
                BK_DUM: begin
                    for (int i = 0; i < FIQ_PRIV; i++) begin
                        state_d.dum_hi[i] = '0;
                    end
                end
                default: begin
                    if (new_bank == BK_FIQ) begin
                        for (int i = 0; i < USR_SHARED; i++) begin
                            state_d.usr_hi[i] = state_d.live[BANK_LO + i];
                        end
                    end
                    state_d.priv[priv_slot(cur_bank)][0] = state_d.live[BANK_LO + USR_SHARED];
                    state_d.priv[priv_slot(cur_bank)][1] = state_d.live[BANK_LO + USR_SHARED + 1];
                end
            endcase

            // load incoming bank
            case (new_bank)
                BK_FIQ: begin
                    for (int i = 0; i < FIQ_PRIV; i++) begin
                        state_d.live[BANK_LO + i] = state_d.fiq_hi[i];
                    end
                end
                BK_DUM: begin
                    for (int i = 0; i < FIQ_PRIV; i++) begin
                        state_d.live[BANK_LO + i] = '0;
                    end
                end
                default: begin
                    if (cur_bank == BK_FIQ) begin
                        for (int i = 0; i < USR_SHARED; i++) begin
                            state_d.live[BANK_LO + i] = state_d.usr_hi[i];
                        end
                    end
                    state_d.live[BANK_LO + USR_SHARED]     = state_d.priv[priv_slot(new_bank)][0];
                    state_d.live[BANK_LO + USR_SHARED + 1] = state_d.priv[priv_slot(new_bank)][1];
                end
            endcase
        end

        if (mode_we) begin
            state_d.mode = mode_wdata;
        end

        // ordinary write goes to the new mode's register
        if (wr_en) begin
            state_d.live[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.mode <= RESET_MODE;
        end else begin
            state_q <= state_d;
        end
    end

    logic [NUM_REGS-1:0][DATA_W-1:0]   chk_live;
    logic [USR_SHARED-1:0][DATA_W-1:0] chk_usr_hi;
    assign chk_live   = state_q.live;
    assign chk_usr_hi = state_q.usr_hi;

endmodule

// File: rtl/mbrf_checks.sv
module mbrf_checks
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              wr_en,
    input logic [ADDR_W-1:0]                 wr_addr,
    input logic [DATA_W-1:0]                 wr_data,
    input logic                              mode_we,
    input logic [MODE_W-1:0]                 mode_wdata,
    input logic [MODE_W-1:0]                 cur_mode,
    input logic                              dbg_we,
    input bank_e                             cur_bank,
    input bank_e                             new_bank,
    input logic [NUM_REGS-1:0][DATA_W-1:0]   live_q,
    input logic [USR_SHARED-1:0][DATA_W-1:0] usr_hi_q
);

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> live_q[$past(wr_addr)] == $past(wr_data));

    a_r7_same_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && new_bank == cur_bank && !wr_en && !dbg_we) |=> $stable(live_q));

    a_r5_fiq_entry_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && new_bank == BK_FIQ && cur_bank != BK_FIQ && cur_bank != BK_DUM && !dbg_we)
        |=> usr_hi_q == $past(live_q[12:8]));

    a_r6_dummy_entry_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && new_bank == BK_DUM && cur_bank != BK_DUM && !wr_en) |=> live_q[14:8] == '0);

    a_r8_shared_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !wr_en && !dbg_we)
        |=> (live_q[7:0] == $past(live_q[7:0])) && (live_q[15] == $past(live_q[15])));

    a_r11_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> cur_mode == $past(mode_wdata));

endmodule

bind mbrf_regfile mbrf_checks #(.DATA_W(DATA_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .cur_mode   (cur_mode),
    .dbg_we     (dbg_we),
    .cur_bank   (cur_bank),
    .new_bank   (new_bank),
    .live_q     (chk_live),
    .usr_hi_q   (chk_usr_hi)
);

// File: tb/mbrf_regfile_bench.sv
module mbrf_regfile_bench;

    localparam int CLK_P = 10;
    localparam int DW    = 32;

    localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
                           M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F, M_BAD = 5'h05,
                           M_SVC_ALT = 5'h03, M_FIQ_ALT = 5'h01;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0, dbg_addr = '0;
    logic [DW-1:0] rd_data_a, rd_data_b, dbg_rdata;
    logic          wr_en = 1'b0, mode_we = 1'b0, dbg_we = 1'b0;
    logic [DW-1:0] wr_data = '0, dbg_wdata = '0;
    logic [4:0]    mode_wdata = '0, dbg_mode = '0, cur_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          port;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    mbrf_regfile #(.DATA_W(DW)) u_mbrf_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .cur_mode(cur_mode),
        .dbg_we(dbg_we), .dbg_mode(dbg_mode), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (sb.size() > 0);
            it = sb.pop_front();
            case (it.port)
                0:       act = rd_data_a;
                1:       act = rd_data_b;
                2:       act = dbg_rdata;
                default: act = {27'd0, cur_mode};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push_exp(input int port, input logic [31:0] exp, input string tag);
        item_t it;
        it.port = port; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic look(input int port, input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        if (port == 0) rd_addr_a = a; else rd_addr_b = a;
        #1;
        push_exp(port, exp, tag);
    endtask

    task automatic dlook(input logic [4:0] m, input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        dbg_mode = m; dbg_addr = a;
        #1;
        push_exp(2, exp, tag);
    endtask

    task automatic mlook(input logic [4:0] m, input string tag);
        @(negedge clk);
        #1;
        push_exp(3, {27'd0, m}, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic [4:0] m);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        @(posedge clk); #1;
        mode_we = 1'b0;
    endtask

    task automatic set_mode_wr(input logic [4:0] m, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        mode_we = 1'b0; wr_en = 1'b0;
    endtask

    task automatic set_mode_dwr(input logic [4:0] m, input logic [4:0] dm, input logic [3:0] a,
                                input logic [31:0] d);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        dbg_we = 1'b1; dbg_mode = dm; dbg_addr = a; dbg_wdata = d;
        @(posedge clk); #1;
        mode_we = 1'b0; dbg_we = 1'b0;
    endtask

    task automatic dwr(input logic [4:0] m, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        dbg_we = 1'b1; dbg_mode = m; dbg_addr = a; dbg_wdata = d;
        @(posedge clk); #1;
        dbg_we = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        mlook(M_SVC, "R1 reset mode");
        look(0, 4'd0,  32'h0, "R1 reset r0");
        look(1, 4'd13, 32'h0, "R1 reset r13");
        dlook(M_FIQ, 4'd9, 32'h0, "R1 reset fiq shadow");

        // R3 write/read in supervisor
        for (int i = 0; i < 15; i++) wr(4'(i), 32'hA000_0000 | i);
        look(0, 4'd0,  32'hA000_0000, "R3 read a r0");
        look(1, 4'd14, 32'hA000_000E, "R3 read b r14");

        // R4 switch to interrupt bank
        set_mode(M_IRQ);
        look(0, 4'd13, 32'h0, "R4 irq r13 restored");
        look(1, 4'd8,  32'hA000_0008, "R8 r8 shared in irq");
        wr(4'd13, 32'hB000_000D);
        wr(4'd14, 32'hB000_000E);
        dlook(M_SVC, 4'd13, 32'hA000_000D, "R9 svc r13 shadow");
        dlook(M_IRQ, 4'd13, 32'hB000_000D, "R9 current r13 live");

        // R5 enter fast-interrupt bank
        set_mode(M_FIQ);
        look(0, 4'd8,  32'h0, "R5 fiq r8 loaded");
        look(1, 4'd12, 32'h0, "R5 fiq r12 loaded");
        look(0, 4'd7,  32'hA000_0007, "R8 r7 shared in fiq");
        wr(4'd8,  32'hC000_0008);
        wr(4'd13, 32'hC000_000D);
        dlook(M_USR, 4'd8, 32'hA000_0008, "R9 user r8 from user store");
        dlook(M_IRQ, 4'd14, 32'hB000_000E, "R9 irq r14 shadow");

        // R5 leave to supervisor
        set_mode(M_SVC);
        look(0, 4'd8,  32'hA000_0008, "R5 r8 reloaded");
        look(1, 4'd12, 32'hA000_000C, "R5 r12 reloaded");
        look(0, 4'd13, 32'hA000_000D, "R4 svc r13 back");
        dlook(M_FIQ, 4'd8,  32'hC000_0008, "R5 fiq r8 saved");
        dlook(M_FIQ, 4'd13, 32'hC000_000D, "R5 fiq r13 saved");

        // R7 same bank, different code
        set_mode(M_SVC_ALT);
        mlook(M_SVC_ALT, "R11 mode alt");
        look(0, 4'd13, 32'hA000_000D, "R7 no swap r13");

        // R10 write in the switching cycle lands in new mode
        set_mode_wr(M_ABT, 4'd13, 32'hD000_000D);
        look(0, 4'd13, 32'hD000_000D, "R10 abt r13 written");
        dlook(M_SVC, 4'd13, 32'hA000_000D, "R10 svc r13 preserved");

        // R9 debug write to other bank and current bank
        dwr(M_UND, 4'd14, 32'hE000_000E);
        set_mode(M_UND);
        look(1, 4'd14, 32'hE000_000E, "R9 und r14 from debug write");
        dwr(M_UND, 4'd0, 32'hE000_0000);
        look(0, 4'd0, 32'hE000_0000, "R9 debug write live r0");

        // R6 dummy bank
        dwr(M_BAD, 4'd10, 32'h0000_00DD);
        dlook(M_BAD, 4'd10, 32'h0000_00DD, "R9 dummy shadow written");
        wr(4'd8, 32'hF000_0008);
        set_mode(M_BAD);
        look(0, 4'd8,  32'h0, "R6 entry r8 zero");
        look(1, 4'd13, 32'h0, "R6 entry r13 zero");
        look(0, 4'd10, 32'h0, "R6 entry r10 zero");
        wr(4'd9, 32'h0000_0099);
        dlook(5'h14, 4'd9, 32'h0000_0099, "R2 code 14h is dummy bank");
        set_mode(M_SYS);
        dlook(M_BAD, 4'd10, 32'h0, "R6 exit clears shadow r10");
        dlook(M_BAD, 4'd9,  32'h0, "R6 exit clears shadow r9");
        look(0, 4'd9,  32'h0000_0099, "R6 r9 stays live on exit");
        look(1, 4'd13, 32'h0, "R4 sys r13 own copy");
        dlook(M_UND, 4'd14, 32'hE000_000E, "R4 und r14 saved");

        // R8 r15 shared, R2 alternate fast-interrupt code
        wr(4'd15, 32'h0000_0F15);
        set_mode(M_FIQ_ALT);
        look(0, 4'd15, 32'h0000_0F15, "R8 r15 shared");
        look(1, 4'd8,  32'hC000_0008, "R2 code 01h is fiq bank");
        set_mode(M_FIQ);
        look(0, 4'd8,  32'hC000_0008, "R7 fiq codes same bank");
        set_mode(M_USR);
        look(0, 4'd9,  32'h0000_0099, "R5 r9 reloaded from user store");
        look(1, 4'd13, 32'h0, "R4 user r13");

        // R10 debug write in the switching cycle is saved with the old bank
        set_mode_dwr(M_IRQ, M_USR, 4'd13, 32'h0000_1313);
        look(0, 4'd13, 32'hB000_000D, "R10 irq r13 restored");
        dlook(M_USR, 4'd13, 32'h0000_1313, "R10 debug write saved");
        mlook(M_IRQ, "R11 mode irq");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule